// File: doc/BRIEF.md
# Configurable UART Receiver Engine

This block receives asynchronous serial characters on a single input line. A programmable divider produces a clock enable at sixteen times the bit rate. Every bit of the frame is sampled once, at the middle of its sixteen oversample ticks. The frame format is set through a small register-style write port:

- 7, 8 or 9 data bits, sent least significant bit first;
- parity that is off, even or odd;
- one or two stop bits.

Each finished character moves from the shift register into a one-entry holding buffer. At that moment the block raises a one-cycle interrupt pulse and updates the parity and framing error flags. If the buffer is still unread when a new frame reaches the bit just before its final stop bit, the block declares an overrun. An overrun leaves the buffer contents as they were.

A read strobe empties the buffer and clears the error flags. An optional flow-control output, active low, asks the far end to send only while reception is enabled and the buffer is empty.

Top module: `uart_rx_engine`

## Requirements
- R1: The control register (`cfg_sel`=0, bits [6:0] of `cfg_wdata`) holds the following fields. The received character appears right-justified on `rx_data`, with zeros above the character length.

| Bits | Field |
|---|---|
| [1:0] | length: 0 = 7 bits, 1 = 8 bits, 2 = 9 bits, 3 = 8 bits |
| 2 | parity enable |
| 3 | parity select: 1 = odd, 0 = even |
| 4 | two stop bits |
| 5 | receive enable |
| 6 | flow-control enable |

- R2: The divisor register (`cfg_sel`=1) holds n, from 0 to 255. The oversample enable fires once every n+1 clocks, and one bit lasts 16 oversample ticks. The bit rate is therefore fclk/(16(n+1)).
- R3: Frames are received only while receive enable is 1. A low line starts a frame only if it is still low when sampled 8 oversample ticks later. A line that is high at that mid-bit sample is ignored, and the receiver goes back to idle.
- R4: With parity enabled, `err_parity` is set when the number of ones across the data bits and the parity bit is odd under even parity, or even under odd parity. The flag changes only when a character is transferred into the buffer.
- R5: `err_frame` is set when any configured stop bit is sampled low. The flag changes only when a character is transferred into the buffer.
- R6: When the buffer is still full at the sample of the bit just before the last stop bit, the frame is not transferred. `rx_data` keeps its old value, no interrupt is raised, and `err_overrun` is set at the end of the frame. A read that lands after that decision sample does not prevent the overrun.
- R7: `err_sum` is 1 exactly when at least one of `err_overrun`, `err_frame` or `err_parity` is 1.
- R8: A transfer into the buffer raises `rx_irq` for exactly one clock and sets `rx_full`.
- R9: A one-cycle `rd_strobe` clears `rx_full`, `err_overrun`, `err_frame` and `err_parity`.
- R10: With flow control enabled, `rts_n` is 0 only while receive enable is 1 and the buffer is empty. In every other case `rts_n` is 1.
- R11: After reset, every flag and `rx_data` are 0, `rts_n` is 1, and both configuration registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the control register, 1 selects the divisor register |
| cfg_wdata | input | 8 | Configuration write data |
| rxd | input | 1 | Serial receive line, idle high |
| rd_strobe | input | 1 | Buffer read, one cycle |
| rx_data | output | 9 | Received character, right-justified |
| rx_full | output | 1 | Holding buffer holds an unread character |
| err_overrun | output | 1 | Overrun flag |
| err_frame | output | 1 | Framing error flag |
| err_parity | output | 1 | Parity error flag |
| err_sum | output | 1 | OR of the three error flags |
| rx_irq | output | 1 | Receive-complete pulse |
| rts_n | output | 1 | Active-low receive request |

## Verification
The hardest situation to reach from the ports is the overrun decision window. This window is the single bit between the sample of the bit before the last stop bit and the final stop sample. A read that lands inside it still loses the new character, while a read just before it saves the character. The bench runs the frame driver and a timed read strobe in parallel, placing the read on a chosen bit boundary of the second frame: once early in the frame, and once at the start of the stop bit. This shows that the decision is taken at the earlier sample and not at the end of the frame.

// File: rtl/uart_rx_pkg.sv
// Package: shared types and constants for the UART receiver engine.
// Assumes the character length never exceeds RX_DATA_MAX bits.
package uart_rx_pkg;

    localparam int RX_DATA_MAX = 9;
    localparam int RX_CNT_W    = $clog2(RX_DATA_MAX + 1);
    localparam int RX_CFG_W    = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP1,
        ST_STOP2
    } rx_state_t;

    // Control register layout, most significant field first.
    typedef struct packed {
        logic       rts_fn;
        logic       rx_en;
        logic       two_stop;
        logic       par_odd;
        logic       par_en;
        logic [1:0] len_code;
    } rx_cfg_t;

    // Maps the length code to a number of data bits.
    function automatic logic [RX_CNT_W-1:0] len_to_bits(input logic [1:0] code);
        case (code)
            2'd0:    return RX_CNT_W'(7);
            2'd2:    return RX_CNT_W'(9);
            default: return RX_CNT_W'(8);
        endcase
    endfunction

endpackage

// File: rtl/urx_cfg_regs.sv
// Module: configuration registers (control and divisor).
// Assumes the write data width is at least the control register width.
module urx_cfg_regs
    import uart_rx_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [DIV_W-1:0] cfg_wdata,
    output rx_cfg_t          cfg,
    output logic [DIV_W-1:0] div
);

    // Capture configuration writes into the selected register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
            div <= '0;
        end else if (cfg_we) begin
            if (cfg_sel) div <= cfg_wdata;
            else         cfg <= rx_cfg_t'(cfg_wdata[RX_CFG_W-1:0]);
        end
    end

endmodule

// File: rtl/urx_tick_gen.sv
// Module: oversample clock enable, one pulse every div+1 clocks.
// Assumes div may change at any time; the counter wraps at the new limit.
module urx_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    // Count clocks and pulse tick when the divisor limit is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= div) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

endmodule

// File: rtl/urx_frame_fsm.sv
// Module: serial frame receiver. Synchronises the line, confirms the
// start bit at mid-bit, samples each bit at its centre, and hands a
// finished character with its error status to the holding stage.
// Assumes the format fields are stable while a frame is in progress.
module urx_frame_fsm
    import uart_rx_pkg::*;
#(
    parameter int OS_RATE     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick,
    input  logic                   rxd,
    input  logic                   rx_en,
    input  logic [1:0]             len_code,
    input  logic                   par_en,
    input  logic                   par_odd,
    input  logic                   two_stop,
    input  logic                   hold_full,
    output logic                   done,
    output logic [RX_DATA_MAX-1:0] done_data,
    output logic                   done_fe,
    output logic                   done_pe,
    output logic                   done_ovr
);

    localparam int          OS_W    = $clog2(OS_RATE);
    localparam logic [OS_W-1:0] OS_MID  = OS_W'(OS_RATE / 2 - 1);
    localparam logic [OS_W-1:0] OS_LAST = OS_W'(OS_RATE - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rxs;
    rx_state_t              state;
    logic [OS_W-1:0]        os;
    logic [RX_CNT_W-1:0]    bit_cnt;
    logic [RX_CNT_W-1:0]    last_idx;
    logic [RX_CNT_W-1:0]    align_sh;
    logic [RX_DATA_MAX-1:0] shreg;
    logic                   par_acc;
    logic                   fe_acc;
    logic                   ovr_pend;
    logic                   finish_now;

    assign rxs      = sync_q[SYNC_STAGES-1];
    assign last_idx = len_to_bits(len_code) - 1'b1;
    assign align_sh = RX_CNT_W'(RX_DATA_MAX) - len_to_bits(len_code);

    // Marks the centre sample of the final stop bit.
    always_comb begin
        finish_now = tick && rx_en && (os == OS_LAST) &&
                     (((state == ST_STOP1) && !two_stop) || (state == ST_STOP2));
    end

    // Bring the asynchronous line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
    end

    // Frame state machine: start check, bit sampling, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            os        <= '0;
            bit_cnt   <= '0;
            shreg     <= '0;
            par_acc   <= 1'b0;
            fe_acc    <= 1'b0;
            ovr_pend  <= 1'b0;
            done      <= 1'b0;
            done_data <= '0;
            done_fe   <= 1'b0;
            done_pe   <= 1'b0;
            done_ovr  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!rx_en) begin
                state <= ST_IDLE;
                os    <= '0;
            end else if (tick) begin
                case (state)
                    ST_IDLE: begin
                        if (!rxs) begin
                            state <= ST_START;
                            os    <= '0;
                        end
                    end
                    ST_START: begin
                        if (os == OS_MID) begin
                            os <= '0;
                            if (rxs) begin
                                state <= ST_IDLE;
                            end else begin
                                state    <= ST_DATA;
                                bit_cnt  <= '0;
                                par_acc  <= 1'b0;
                                fe_acc   <= 1'b0;
                                ovr_pend <= 1'b0;
                            end
                        end else begin
                            os <= os + 1'b1;
                        end
                    end
                    default: begin
                        if (os == OS_LAST) begin
                            os <= '0;
                            case (state)
                                ST_DATA: begin
                                    shreg   <= {rxs, shreg[RX_DATA_MAX-1:1]};
                                    par_acc <= par_acc ^ rxs;
                                    bit_cnt <= bit_cnt + 1'b1;
                                    if (bit_cnt == last_idx) begin
                                        if (par_en) begin
                                            state <= ST_PAR;
                                        end else begin
                                            state <= ST_STOP1;
                                            if (!two_stop) ovr_pend <= hold_full;
                                        end
                                    end
                                end
                                ST_PAR: begin
                                    par_acc <= par_acc ^ rxs;
                                    state   <= ST_STOP1;
                                    if (!two_stop) ovr_pend <= hold_full;
                                end
                                ST_STOP1: begin
                                    if (two_stop) begin
                                        fe_acc   <= !rxs;
                                        ovr_pend <= hold_full;
                                        state    <= ST_STOP2;
                                    end
                                end
                                default: ;
                            endcase
                        end else begin
                            os <= os + 1'b1;
                        end
                    end
                endcase
                if (finish_now) begin
                    state     <= ST_IDLE;
                    done      <= 1'b1;
                    done_data <= shreg >> align_sh;
                    done_fe   <= fe_acc | !rxs;
                    done_pe   <= par_en && (par_acc != par_odd);
                    done_ovr  <= ovr_pend;
                end
            end
        end
    end

endmodule

// File: rtl/urx_holding.sv
// Module: one-entry holding buffer with error flags, interrupt pulse
// and receive-request output.
// Assumes done pulses for one clock; a transfer outranks a read in
// the same clock.
module urx_holding
    import uart_rx_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   done,
    input  logic [RX_DATA_MAX-1:0] done_data,
    input  logic                   done_fe,
    input  logic                   done_pe,
    input  logic                   done_ovr,
    input  logic                   rd_strobe,
    input  logic                   rx_en,
    input  logic                   rts_fn,
    output logic [RX_DATA_MAX-1:0] rx_data,
    output logic                   rx_full,
    output logic                   err_overrun,
    output logic                   err_frame,
    output logic                   err_parity,
    output logic                   err_sum,
    output logic                   rx_irq,
    output logic                   rts_n
);

    // Buffer load, flag latching, read clearing and interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data     <= '0;
            rx_full     <= 1'b0;
            err_overrun <= 1'b0;
            err_frame   <= 1'b0;
            err_parity  <= 1'b0;
            rx_irq      <= 1'b0;
        end else begin
            rx_irq <= 1'b0;
            if (rd_strobe) begin
                rx_full     <= 1'b0;
                err_overrun <= 1'b0;
                err_frame   <= 1'b0;
                err_parity  <= 1'b0;
            end
            if (done) begin
                if (done_ovr) begin
                    err_overrun <= 1'b1;
                end else begin
                    rx_data    <= done_data;
                    rx_full    <= 1'b1;
                    err_frame  <= done_fe;
                    err_parity <= done_pe;
                    rx_irq     <= 1'b1;
                end
            end
        end
    end

    // Combined error flag and receive-request output.
    always_comb begin
        err_sum = err_overrun | err_frame | err_parity;
        rts_n   = rts_fn ? !(rx_en && !rx_full) : 1'b1;
    end

endmodule

// File: rtl/uart_rx_engine.sv
// Module: top of the UART receiver engine. Wires the configuration
// registers, oversample tick generator, frame receiver and holding
// buffer together.
// Assumes rxd idles high and rd_strobe lasts one clock per read.
module uart_rx_engine
    import uart_rx_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int OS_RATE     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic                   cfg_sel,
    input  logic [DIV_W-1:0]       cfg_wdata,
    input  logic                   rxd,
    input  logic                   rd_strobe,
    output logic [RX_DATA_MAX-1:0] rx_data,
    output logic                   rx_full,
    output logic                   err_overrun,
    output logic                   err_frame,
    output logic                   err_parity,
    output logic                   err_sum,
    output logic                   rx_irq,
    output logic                   rts_n
);

    rx_cfg_t                cfg;
    logic [DIV_W-1:0]       div;
    logic                   tick;
    logic                   done;
    logic [RX_DATA_MAX-1:0] done_data;
    logic                   done_fe;
    logic                   done_pe;
    logic                   done_ovr;

    urx_cfg_regs #(.DIV_W(DIV_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg       (cfg),
        .div       (div)
    );

    urx_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .div   (div),
        .tick  (tick)
    );

    urx_frame_fsm #(.OS_RATE(OS_RATE), .SYNC_STAGES(SYNC_STAGES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .rxd       (rxd),
        .rx_en     (cfg.rx_en),
        .len_code  (cfg.len_code),
        .par_en    (cfg.par_en),
        .par_odd   (cfg.par_odd),
        .two_stop  (cfg.two_stop),
        .hold_full (rx_full),
        .done      (done),
        .done_data (done_data),
        .done_fe   (done_fe),
        .done_pe   (done_pe),
        .done_ovr  (done_ovr)
    );

    urx_holding u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .done        (done),
        .done_data   (done_data),
        .done_fe     (done_fe),
        .done_pe     (done_pe),
        .done_ovr    (done_ovr),
        .rd_strobe   (rd_strobe),
        .rx_en       (cfg.rx_en),
        .rts_fn      (cfg.rts_fn),
        .rx_data     (rx_data),
        .rx_full     (rx_full),
        .err_overrun (err_overrun),
        .err_frame   (err_frame),
        .err_parity  (err_parity),
        .err_sum     (err_sum),
        .rx_irq      (rx_irq),
        .rts_n       (rts_n)
    );

endmodule

// File: rtl/urx_checks.sv
// Module: property checker for the UART receiver engine, bound to the top.
// Assumes the clock runs and reset is asserted at the start.
module urx_checks
    import uart_rx_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   rd_strobe,
    input logic [RX_DATA_MAX-1:0] rx_data,
    input logic                   rx_full,
    input logic                   err_overrun,
    input logic                   err_frame,
    input logic                   err_parity,
    input logic                   rx_irq,
    input logic                   rts_n
);

    // R8: a transfer pulse comes with a full buffer
    a_r8_irq_with_full: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> rx_full);

    // R8: the interrupt lasts a single clock
    a_r8_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);

    // R6: a full buffer is never overwritten
    a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |=> (!rx_full || $stable(rx_data)));

    // R6: an overrun never comes with a transfer pulse
    a_r6_ovr_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_overrun) |-> !rx_irq);

    // R4: the parity flag rises only at a transfer
    a_r4_pe_at_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_parity) |-> rx_irq);

    // R5: the framing flag rises only at a transfer
    a_r5_fe_at_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_frame) |-> rx_irq);

    // R9: a read empties the buffer unless a transfer lands at once
    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> (rx_irq || (!rx_full && !err_frame && !err_parity)));

    // R10: no receive request while the buffer is full
    a_r10_rts_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> rts_n);

endmodule

bind uart_rx_engine urx_checks u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_strobe   (rd_strobe),
    .rx_data     (rx_data),
    .rx_full     (rx_full),
    .err_overrun (err_overrun),
    .err_frame   (err_frame),
    .err_parity  (err_parity),
    .rx_irq      (rx_irq),
    .rts_n       (rts_n)
);

// File: tb/uart_rx_engine_test.sv
// Bench: vector table of frame formats, then directed tests for reset,
// enable, start glitch, flow control and the overrun window.
module uart_rx_engine_test;

    typedef struct packed {
        logic [6:0] ctrl;
        logic [7:0] div;
        logic [8:0] data;
        logic       bad_par;
        logic       bad_stop;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VEC [NVEC] = '{
        '{7'b0100001, 8'd0, 9'h0A5, 1'b0, 1'b0},   // 8 bits, no parity, 1 stop
        '{7'b0100100, 8'd0, 9'h0B5, 1'b0, 1'b0},   // 7 bits, even parity
        '{7'b0111110, 8'd0, 9'h1A3, 1'b0, 1'b0},   // 9 bits, odd parity, 2 stop
        '{7'b0100101, 8'd0, 9'h03C, 1'b1, 1'b0},   // 8 bits, even parity, bad parity
        '{7'b0110001, 8'd0, 9'h081, 1'b0, 1'b1},   // 8 bits, 2 stop, first stop low
        '{7'b0100001, 8'd3, 9'h05A, 1'b0, 1'b0},   // divisor 3
        '{7'b0101100, 8'd0, 9'h07F, 1'b1, 1'b0}    // 7 bits, odd parity, bad parity
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_sel = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       rxd = 1'b1;
    logic       rd_strobe = 1'b0;
    logic [8:0] rx_data;
    logic       rx_full, err_overrun, err_frame, err_parity, err_sum, rx_irq, rts_n;

    int n_tests = 0;
    int n_fail  = 0;
    int irq_cnt = 0;

    always #5 clk = ~clk;

    uart_rx_engine uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_sel     (cfg_sel),
        .cfg_wdata   (cfg_wdata),
        .rxd         (rxd),
        .rd_strobe   (rd_strobe),
        .rx_data     (rx_data),
        .rx_full     (rx_full),
        .err_overrun (err_overrun),
        .err_frame   (err_frame),
        .err_parity  (err_parity),
        .err_sum     (err_sum),
        .rx_irq      (rx_irq),
        .rts_n       (rts_n)
    );

    always @(posedge clk) if (rst_n && rx_irq) irq_cnt <= irq_cnt + 1;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic write_reg(input logic sel, input logic [7:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_read();
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic drive_bit(input logic v, input int per);
        rxd = v;
        repeat (per) @(negedge clk);
    endtask

    task automatic send_frame(input logic [8:0] d, input int nb, input logic pen,
                              input logic podd, input logic two, input logic bad_par,
                              input logic bad_stop, input int per);
        logic p;
        p = podd;
        drive_bit(1'b0, per);
        for (int b = 0; b < nb; b++) begin
            drive_bit(d[b], per);
            p = p ^ d[b];
        end
        if (pen) drive_bit(p ^ bad_par, per);
        drive_bit(!bad_stop, per);
        if (two) drive_bit(1'b1, per);
        drive_bit(1'b1, 2 * per);
    endtask

    // 8 bits, no parity, one stop, divisor 0
    task automatic send8(input logic [7:0] d);
        send_frame({1'b0, d}, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        int base;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        check("R11", "rx_full", rx_full, 0);
        check("R11", "err_sum", err_sum, 0);
        check("R11", "err_overrun", err_overrun, 0);
        check("R11", "rx_data", rx_data, 0);
        check("R11", "rx_irq", rx_irq, 0);
        check("R11", "rts_n", rts_n, 1);

        // R3: receiver disabled after reset, frame ignored
        base = irq_cnt;
        send8(8'h3C);
        check("R3", "disabled full", rx_full, 0);
        check("R3", "disabled irq", irq_cnt, base);

        // R1 R2 R4 R5 R7 R8 R9: vector table
        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            int nb;
            logic [8:0] exp_d;
            v = VEC[i];
            nb = (v.ctrl[1:0] == 2'd0) ? 7 : (v.ctrl[1:0] == 2'd2) ? 9 : 8;
            exp_d = v.data & 9'((1 << nb) - 1);
            write_reg(1'b1, v.div);
            write_reg(1'b0, {1'b0, v.ctrl});
            base = irq_cnt;
            send_frame(v.data, nb, v.ctrl[2], v.ctrl[3], v.ctrl[4],
                       v.bad_par, v.bad_stop, 16 * (int'(v.div) + 1));
            check("R1", "rx_data", rx_data, exp_d);
            check("R8", "rx_full", rx_full, 1);
            check("R8", "irq count", irq_cnt, base + 1);
            check("R4", "err_parity", err_parity, v.ctrl[2] & v.bad_par);
            check("R5", "err_frame", err_frame, v.bad_stop);
            check("R7", "err_sum", err_sum, (v.ctrl[2] & v.bad_par) | v.bad_stop);
            do_read();
            check("R9", "full after read", rx_full, 0);
            check("R9", "sum after read", err_sum, 0);
        end

        write_reg(1'b1, 8'd0);
        write_reg(1'b0, 8'h21);

        // R3: short low pulse rejected at the mid-bit check
        base = irq_cnt;
        @(negedge clk);
        rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (40) @(negedge clk);
        check("R3", "glitch full", rx_full, 0);
        check("R3", "glitch irq", irq_cnt, base);
        send8(8'hC3);
        check("R3", "frame after glitch", rx_data, 9'h0C3);
        do_read();

        // R10: receive-request output
        write_reg(1'b0, 8'h61);
        check("R10", "rts empty", rts_n, 0);
        send8(8'h5E);
        check("R10", "rts full", rts_n, 1);
        do_read();
        check("R10", "rts after read", rts_n, 0);
        write_reg(1'b0, 8'h41);
        check("R10", "rts disabled rx", rts_n, 1);
        write_reg(1'b0, 8'h21);
        check("R10", "rts function off", rts_n, 1);

        // R6: overrun with no read
        base = irq_cnt;
        send8(8'h11);
        send8(8'h22);
        check("R6", "data kept", rx_data, 9'h011);
        check("R6", "overrun", err_overrun, 1);
        check("R6", "irq only first", irq_cnt, base + 1);
        check("R7", "sum overrun", err_sum, 1);
        do_read();
        check("R9", "overrun cleared", err_overrun, 0);

        // R6: read after the decision sample still overruns
        send8(8'h33);
        base = irq_cnt;
        fork
            send8(8'h44);
            begin
                repeat (144) @(negedge clk);
                rd_strobe = 1'b1;
                @(negedge clk);
                rd_strobe = 1'b0;
            end
        join
        check("R6", "late read overrun", err_overrun, 1);
        check("R6", "late read data", rx_data, 9'h033);
        check("R6", "late read full", rx_full, 0);
        check("R6", "late read irq", irq_cnt, base);
        do_read();

        // R6: read before the decision sample avoids overrun
        send8(8'h55);
        base = irq_cnt;
        fork
            send8(8'h66);
            begin
                repeat (100) @(negedge clk);
                rd_strobe = 1'b1;
                @(negedge clk);
                rd_strobe = 1'b0;
            end
        join
        check("R6", "early read no overrun", err_overrun, 0);
        check("R6", "early read data", rx_data, 9'h066);
        check("R8", "early read irq", irq_cnt, base + 1);
        do_read();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule